// File: doc/BRIEF.md
# Dual Prescaled Interval Timer

This block provides two 8-bit reloading down-counters and a programmable 16-bit prescaler. All timer setup goes through one 24-bit control word. Each half of the word configures one timer: its reload divider, its mode, its interrupt acknowledge, and its tick source. The same write that arms a timer can therefore also acknowledge its pending interrupt. The prescaler divides a base tick-enable input to make a flexible tick. Timer 1 can also count timer 0 underflows, so the two timers can be chained into a 16-bit-range interval.

Oscillators are modelled as single-cycle tick-enable inputs. `slow_tick` is the fixed low-rate source. `base_tick` feeds the prescaler. Software reads the live timer counts and the prescaler count directly. The elapsed ticks in the current period equal the divider minus the count, taken modulo 256. Each timer sets a sticky underflow flag. The flag reaches an `irq` output only while the matching `irq_en` bit is high.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counts read 0, both flags are clear, `irq` is 0, the prescaler count and reload are all ones, and both timers are stopped, so ticks do not change their counts.
- R2: A control write with a timer's mode bit (field bit 8) at 0 stops that timer and loads the field's divider bits [7:0] into its count. The count then holds.
- R3: A control write with mode bit 1 starts the timer from its current count. The count then falls by one on each cycle in which its selected tick is high.
- R4: A running timer whose count is 1 and which gets a tick reloads its stored divider in that same cycle and sets its flag. The period is therefore exactly the divider in ticks, with no lost tick.
- R5: A divider of 0 gives a period of 256 ticks. The count reads 0, then 255, and so on down to 1.
- R6: Field bits [11:10] choose the tick source. 0 is `slow_tick`, 1 is the prescaled tick, 2 is timer 0 underflow (timer 1 only; on timer 0 it gives no tick), and 3 is no tick.
- R7: A prescaler write sets both its reload and its count. The count falls on each `base_tick`. A `base_tick` at count 0 produces one prescaled tick and reloads, so the period is reload+1 base ticks.
- R8: Field bit 9 at 1 clears the timer's flag, and at 0 leaves the flag alone. An underflow in the same cycle as a clear leaves the flag set.
- R9: `irq[i]` is high exactly when timer i's flag is set and `irq_en[i]` is high.
- R10: In cascade mode, timer 1 decrements once per timer 0 underflow, in the same cycle as that underflow.
- R11: Control word bits [11:0] form timer 0's field and bits [23:12] form timer 1's field. Every write updates both timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 24 | Control word, two 12-bit timer fields |
| presc_we | input | 1 | Prescaler reload write strobe |
| presc_wdata | input | 16 | Prescaler reload value |
| base_tick | input | 1 | Prescaler input tick enable |
| slow_tick | input | 1 | Fixed low-rate tick enable |
| irq_en | input | 2 | Per-timer interrupt mask |
| t0_count | output | 8 | Timer 0 current count |
| t1_count | output | 8 | Timer 1 current count |
| presc_count | output | 16 | Prescaler current count |
| irq | output | 2 | Masked underflow interrupts |

## Verification
The bench targets the reload boundary at count 1. A design that reloads one tick late, or lets the count reach 0, returns a count one off from expected after a whole number of periods. A divider of 0 must run a full 256 ticks; a design that treats 0 as 0 or 1 either underflows at once or stalls. The bench also issues an acknowledge in the same cycle as an underflow, which a design with clear-over-set priority would lose. It checks the prescaler's reload+1 period and that timer 1 advances in cascade exactly once per timer 0 underflow; an off-by-one period, or a cascade wired to the wrong source, shifts the readback counts.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int DIV_W   = 8;
  localparam int NUM_TMR = 2;
  localparam int FIELD_W = DIV_W + 4;
  localparam int CTRL_W  = FIELD_W * NUM_TMR;

  typedef enum logic [1:0] {
    SEL_SLOW = 2'd0,
    SEL_FLEX = 2'd1,
    SEL_CASC = 2'd2,
    SEL_NONE = 2'd3
  } tick_sel_e;

  // Packed from MSB: source select, acknowledge, run, divider
  typedef struct packed {
    tick_sel_e           sel;
    logic                ack;
    logic                run;
    logic [DIV_W-1:0]    div;
  } tmr_field_t;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         base_tick,
  output logic         flex_tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] reload_q, reload_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_zero;

  assign at_zero   = (cnt_q == '0);
  assign flex_tick = base_tick && at_zero;

  always_comb begin
    reload_d = reload_q;
    cnt_d    = cnt_q;
    if (wr_en) begin
      reload_d = wr_data;
      cnt_d    = wr_data;
    end else if (base_tick) begin
      cnt_d = at_zero ? reload_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= ALL_ONES;
      cnt_q    <= ALL_ONES;
    end else begin
      reload_q <= reload_d;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_PRESC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && at_zero && !wr_en) |=> (cnt_q == $past(reload_q))) else $error("presc reload"); // R7

  AST_PRESC_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && !at_zero && !wr_en) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("presc step"); // R7
endmodule

// File: rtl/dit_timer.sv
module dit_timer
  import dit_pkg::*;
#(
  parameter bit ALLOW_CASC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tmr_field_t       field,
  input  logic             slow_tick,
  input  logic             flex_tick,
  input  logic             casc_tick,
  output logic [DIV_W-1:0] count,
  output logic             uflow,
  output logic             flag
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] count_q, count_d;
  logic [DIV_W-1:0] div_q, div_d;
  tick_sel_e        sel_q, sel_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic             tick;
  logic             load_now;

  always_comb begin
    unique case (sel_q)
      SEL_SLOW: tick = slow_tick;
      SEL_FLEX: tick = flex_tick;
      SEL_CASC: tick = ALLOW_CASC ? casc_tick : 1'b0;
      default:  tick = 1'b0;
    endcase
  end

  assign uflow    = run_q && tick && (count_q == ONE);
  assign load_now = wr_en && !field.run;

  always_comb begin
    count_d = count_q;
    div_d   = div_q;
    sel_d   = sel_q;
    run_d   = run_q;
    if (wr_en) begin
      div_d = field.div;
      sel_d = field.sel;
      run_d = field.run;
    end
    if (load_now) begin
      count_d = field.div;
    end else if (run_q && tick) begin
      count_d = (count_q == ONE) ? div_q : count_q - 1'b1;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (uflow)                  flag_d = 1'b1;
    else if (wr_en && field.ack) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      div_q   <= '0;
      sel_q   <= SEL_SLOW;
      run_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      div_q   <= div_d;
      sel_q   <= sel_d;
      run_q   <= run_d;
      flag_q  <= flag_d;
    end
  end

  assign count = count_q;
  assign flag  = flag_q;

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(count_q)) else $error("stopped count moved"); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && count_q != ONE && !wr_en) |=> (count_q == $past(count_q) - 1'b1)) else $error("step"); // R3

  AST_RELOAD_ON_UFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !wr_en) |=> (count_q == $past(div_q))) else $error("reload"); // R4

  AST_UFLOW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> flag_q) else $error("flag lost"); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && field.ack && !uflow) |=> !flag_q) else $error("ack"); // R8
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int PRESC_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic               presc_we,
  input  logic [PRESC_W-1:0] presc_wdata,
  input  logic               base_tick,
  input  logic               slow_tick,
  input  logic [NUM_TMR-1:0] irq_en,
  output logic [DIV_W-1:0]   t0_count,
  output logic [DIV_W-1:0]   t1_count,
  output logic [PRESC_W-1:0] presc_count,
  output logic [NUM_TMR-1:0] irq
);
  logic                         flex_tick;
  logic [NUM_TMR-1:0]           uflow;
  logic [NUM_TMR-1:0]           flag;
  logic [NUM_TMR-1:0][DIV_W-1:0] count;

  dit_prescaler #(.W(PRESC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (presc_we),
    .wr_data   (presc_wdata),
    .base_tick (base_tick),
    .flex_tick (flex_tick),
    .cnt       (presc_count)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic       casc_in;
    tmr_field_t fld;
    assign fld = tmr_field_t'(ctrl_wdata[i*FIELD_W +: FIELD_W]);
    if (i == 0) begin : g_head
      assign casc_in = 1'b0;
    end else begin : g_chain
      assign casc_in = uflow[i-1];
    end
    dit_timer #(.ALLOW_CASC(i != 0)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctrl_we),
      .field     (fld),
      .slow_tick (slow_tick),
      .flex_tick (flex_tick),
      .casc_tick (casc_in),
      .count     (count[i]),
      .uflow     (uflow[i]),
      .flag      (flag[i])
    );
    assign irq[i] = flag[i] & irq_en[i];
  end

  assign t0_count = count[0];
  assign t1_count = count[1];

  AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow[0] && !uflow[1] && !ctrl_we && $past(ctrl_we) == 1'b0 && $past(ctrl_wdata[23:22]) == 2'd2
     && g_tmr[1].u_tmr.run_q && g_tmr[1].u_tmr.sel_q == SEL_CASC)
    |=> (t1_count == $past(t1_count) - 1'b1)) else $error("cascade"); // R10
endmodule

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [23:0] ctrl_wdata = '0;
  logic        presc_we = 1'b0;
  logic [15:0] presc_wdata = '0;
  logic        base_tick = 1'b0;
  logic        slow_tick = 1'b0;
  logic [1:0]  irq_en = 2'b00;
  logic [7:0]  t0_count, t1_count;
  logic [15:0] presc_count;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .presc_we(presc_we), .presc_wdata(presc_wdata), .base_tick(base_tick),
    .slow_tick(slow_tick), .irq_en(irq_en), .t0_count(t0_count),
    .t1_count(t1_count), .presc_count(presc_count), .irq(irq)
  );

  // field: {sel[1:0], ack, run, div[7:0]}
  function automatic logic [11:0] fld(input logic [7:0] d, input logic run,
                                      input logic ack, input logic [1:0] sel);
    return {sel, ack, run, d};
  endfunction

  localparam logic [11:0] IDLE1 = 12'hC00; // stop-and-load 0, no tick

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] f1, input logic [11:0] f0);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = {f1, f0};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic slow(input int n);
    if (n > 0) begin
      @(negedge clk); slow_tick = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  task automatic base(input int n);
    if (n > 0) begin
      @(negedge clk); base_tick = 1'b1;
      repeat (n - 1) @(negedge clk);
      @(negedge clk); base_tick = 1'b0;
    end
  endtask

  typedef struct packed {
    logic [7:0] div;
    logic [8:0] ticks;
    logic [7:0] exp_cnt;
    logic       exp_flag;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{8'd10,  9'd3,   8'd7,   1'b0},
    '{8'd10,  9'd9,   8'd1,   1'b0},
    '{8'd10,  9'd10,  8'd10,  1'b1},
    '{8'd10,  9'd13,  8'd7,   1'b1},
    '{8'd1,   9'd5,   8'd1,   1'b1},
    '{8'd0,   9'd1,   8'd255, 1'b0},
    '{8'd0,   9'd256, 8'd0,   1'b1},
    '{8'd250, 9'd250, 8'd250, 1'b1},
    '{8'd3,   9'd2,   8'd1,   1'b0}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and stopped timers
    chk("R1 t0_count", t0_count, 0);
    chk("R1 t1_count", t1_count, 0);
    chk("R1 presc_count", presc_count, 16'hFFFF);
    irq_en = 2'b11;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    slow(5);
    chk("R1 stopped t0", t0_count, 0);

    // Vector table: timer 0 on slow tick (R3, R4, R5, R11)
    irq_en = 2'b01;
    foreach (VEC[k]) begin
      wr(IDLE1, fld(VEC[k].div, 1'b0, 1'b1, 2'd0));
      chk("R2 load", t0_count, VEC[k].div);
      wr(IDLE1, fld(VEC[k].div, 1'b1, 1'b0, 2'd0));
      slow(int'(VEC[k].ticks));
      chk(VEC[k].div == 0 ? "R5 count" : "R4 count", t0_count, VEC[k].exp_cnt);
      chk("R4 flag via irq", irq[0], VEC[k].exp_flag);
    end

    // R2 stop mid-run and hold
    wr(IDLE1, fld(8'd9, 1'b0, 1'b1, 2'd0));
    wr(IDLE1, fld(8'd9, 1'b1, 1'b0, 2'd0));
    slow(3);
    chk("R3 running", t0_count, 6);
    wr(IDLE1, fld(8'd20, 1'b0, 1'b0, 2'd0));
    slow(4);
    chk("R2 halted", t0_count, 20);

    // R8 / R9: flag, mask, no-op ack, clear ack
    wr(IDLE1, fld(8'd2, 1'b0, 1'b1, 2'd0));
    wr(IDLE1, fld(8'd2, 1'b1, 1'b0, 2'd0));
    slow(2);
    irq_en = 2'b00;
    @(negedge clk);
    chk("R9 masked", irq[0], 0);
    irq_en = 2'b01;
    @(negedge clk);
    chk("R9 unmasked", irq[0], 1);
    wr(IDLE1, fld(8'd2, 1'b1, 1'b0, 2'd0));
    chk("R8 noop keeps flag", irq[0], 1);
    wr(IDLE1, fld(8'd2, 1'b1, 1'b1, 2'd0));
    chk("R8 clear", irq[0], 0);
    // count now 2; one tick -> 1, then underflow together with clear
    slow(1);
    chk("R8 pre", t0_count, 1);
    @(negedge clk);
    slow_tick = 1'b1; ctrl_we = 1'b1; ctrl_wdata = {IDLE1, fld(8'd2, 1'b1, 1'b1, 2'd0)};
    @(negedge clk);
    slow_tick = 1'b0; ctrl_we = 1'b0;
    chk("R8 set wins over clear", irq[0], 1);
    chk("R4 reload with write", t0_count, 2);

    // R6: select none and select cascade on timer 0 give no tick
    wr(IDLE1, fld(8'd5, 1'b0, 1'b1, 2'd3));
    wr(IDLE1, fld(8'd5, 1'b1, 1'b0, 2'd3));
    slow(3); base(3);
    chk("R6 no tick", t0_count, 5);
    wr(IDLE1, fld(8'd5, 1'b1, 1'b0, 2'd2));
    slow(3);
    chk("R6 t0 cascade inert", t0_count, 5);

    // R7: prescaler period reload+1, flexible tick drives timer 0
    @(negedge clk); presc_we = 1'b1; presc_wdata = 16'd3;
    @(negedge clk); presc_we = 1'b0;
    chk("R7 presc load", presc_count, 3);
    wr(IDLE1, fld(8'd2, 1'b0, 1'b1, 2'd1));
    wr(IDLE1, fld(8'd2, 1'b1, 1'b0, 2'd1));
    base(2);
    chk("R7 presc count", presc_count, 1);
    chk("R6 flex idle", t0_count, 2);
    base(2);
    chk("R7 presc reload", presc_count, 3);
    chk("R7 one flex tick", t0_count, 1);
    base(4);
    chk("R7 second flex tick", t0_count, 2);
    chk("R7 flag", irq[0], 1);

    // R10 / R11: timer 1 cascaded from timer 0
    irq_en = 2'b10;
    wr(fld(8'd3, 1'b0, 1'b1, 2'd2), fld(8'd2, 1'b0, 1'b1, 2'd0));
    chk("R11 t1 field", t1_count, 3);
    chk("R11 t0 field", t0_count, 2);
    wr(fld(8'd3, 1'b1, 1'b0, 2'd2), fld(8'd2, 1'b1, 1'b0, 2'd0));
    slow(4);
    chk("R10 t1 after two uflows", t1_count, 1);
    chk("R10 no t1 flag yet", irq[1], 0);
    slow(2);
    chk("R10 t1 reload", t1_count, 3);
    chk("R10 t1 flag", irq[1], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule